// File: doc/BRIEF.md
# Selectable-Tap Input Delay Stack

This block delays four independent operand streams by a programmable number of clocks before they reach a multiplier array. Each lane has a 12-bit capture register that samples its data pins on every rising edge. Behind the capture register sits a 16-entry shift stack. The stack advances only on edges where that lane's active-low push strobe is low. On every other edge it keeps its contents, and the captured word is dropped.

Each lane also has a 4-bit tap word. The tap word is registered and picks which stack entry drives the lane's output. Tap 0 selects the newest entry and tap 15 selects the oldest. Between the capture register and the output, the delay is therefore 1 to 16 pushes.

The stack and the capture register have no reset, so their contents are undefined until software has pushed enough words to fill them. Reset clears only the registered tap words.

The data path has no handshake. Data is accepted on every edge, and each output is a continuous function of state. Because there is no ready signal and nothing to stall, there is no back-pressure. A caller that wants to hold a lane's stack raises that lane's push strobe.

Top module: `tapstack_quad`

## Requirements
- R1: On every rising edge, each lane's capture register loads that lane's `din` field, whatever the state of `push_n`. Lane n uses bits [12n+11:12n].
- R2: On a rising edge with `push_n[n]` low, lane n's entry 0 takes the capture register's previous value, and each entry k (k ≥ 1) takes the previous value of entry k-1.
- R3: On a rising edge with `push_n[n]` high, lane n's stack keeps every entry. The word in the capture register is not stored and is lost.
- R4: Each lane's 4-bit tap field is `tap_sel[4n+3:4n]`. It is registered on every rising edge. From that edge on, `dout[12n+11:12n]` equals stack entry number (registered tap), where entry 0 is the newest.
- R5: With tap 0 and pushes on every edge, a word present on `din` before edge k appears on `dout` right after edge k+1.
- R6: With tap 15 and pushes on every edge, a word present on `din` before edge k appears on `dout` right after edge k+16.
- R7: The lanes are independent. The push strobe, tap word and data of one lane do not affect any other lane's output.
- R8: While `rst_n` is low, every registered tap word is 0. Reset does not alter the capture registers or the stack contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the tap-word registers only |
| din | input | 48 | Four 12-bit operand words, lane 0 in the low bits |
| push_n | input | 4 | Per-lane active-low stack advance strobe |
| tap_sel | input | 16 | Four 4-bit tap words, lane 0 in the low bits |
| dout | output | 48 | Four 12-bit delayed operands, lane 0 in the low bits |

## Verification
The properties compare stack entries against their own values one cycle earlier. They therefore assume that `din`, `push_n` and `tap_sel` carry defined levels on every edge from time zero, even while reset is low. The bench meets this by driving all inputs to known values before the first edge and changing them only on falling edges. It also pushes at least sixteen words into every lane before any check that reads the output. Because of this, no expected value depends on the undefined power-up contents of a stack.

// File: rtl/tapstack_pkg.sv
package tapstack_pkg;
  parameter int OPW   = 12;
  parameter int DEPTH = 16;
  parameter int LANES = 4;
  localparam int SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
endpackage

// File: rtl/tap_inreg.sv
// Capture register: samples the operand pins on every edge.
module tap_inreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/tap_stack.sv
// Shift stack that advances only when the active-low push strobe is low.
module tap_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               push_n,
  input  logic [W-1:0]       in_word,
  output logic [DEPTH*W-1:0] flat
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!push_n) stg[0] <= in_word;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!push_n) stg[i] <= stg[i-1];
      end
    end
    assign flat[i*W +: W] = stg[i];
  end
endmodule

// File: rtl/tap_select.sv
// Registered tap word and the output multiplexer.
module tap_select #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  parameter int SELW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SELW-1:0]    sel_in,
  input  logic [DEPTH*W-1:0] flat,
  output logic [SELW-1:0]    sel_q,
  output logic [W-1:0]       q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_in;
  end

  always_comb begin
    q = flat[W-1:0];
    for (int k = 0; k < DEPTH; k++) begin
      if (SELW'(k) == sel_q) q = flat[k*W +: W];
    end
  end
endmodule

// File: rtl/tap_lane.sv
// One operand lane: capture register, stack and tap selection.
module tap_lane #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  parameter int SELW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       d,
  input  logic               push_n,
  input  logic [SELW-1:0]    sel,
  output logic [W-1:0]       q,
  output logic [W-1:0]       in_o,
  output logic [DEPTH*W-1:0] stk_o,
  output logic [SELW-1:0]    sel_o
);
  logic [W-1:0]       cap;
  logic [DEPTH*W-1:0] flat;

  tap_inreg #(.W(W)) u_cap (
    .clk (clk),
    .d   (d),
    .q   (cap)
  );

  tap_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk     (clk),
    .push_n  (push_n),
    .in_word (cap),
    .flat    (flat)
  );

  tap_select #(.W(W), .DEPTH(DEPTH), .SELW(SELW)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_in (sel),
    .flat   (flat),
    .sel_q  (sel_o),
    .q      (q)
  );

  assign in_o  = cap;
  assign stk_o = flat;
endmodule

// File: rtl/tapstack_quad.sv
// Four independent selectable-tap delay lanes.
module tapstack_quad #(
  parameter int OPW   = tapstack_pkg::OPW,
  parameter int DEPTH = tapstack_pkg::DEPTH,
  parameter int LANES = tapstack_pkg::LANES,
  localparam int SELW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*OPW-1:0]  din,
  input  logic [LANES-1:0]      push_n,
  input  logic [LANES*SELW-1:0] tap_sel,
  output logic [LANES*OPW-1:0]  dout
);
  logic [LANES*OPW-1:0]       in_all;
  logic [LANES*DEPTH*OPW-1:0] stk_all;
  logic [LANES*SELW-1:0]      sel_all;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tap_lane #(.W(OPW), .DEPTH(DEPTH), .SELW(SELW)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (din[l*OPW +: OPW]),
      .push_n (push_n[l]),
      .sel    (tap_sel[l*SELW +: SELW]),
      .q      (dout[l*OPW +: OPW]),
      .in_o   (in_all[l*OPW +: OPW]),
      .stk_o  (stk_all[l*DEPTH*OPW +: DEPTH*OPW]),
      .sel_o  (sel_all[l*SELW +: SELW])
    );
  end
endmodule

// File: rtl/tapstack_quad_chk.sv
module tapstack_quad_chk #(
  parameter int OPW   = 12,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int SELW  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [LANES*OPW-1:0]       din,
  input logic [LANES-1:0]           push_n,
  input logic [LANES*SELW-1:0]      tap_sel,
  input logic [LANES*OPW-1:0]       dout,
  input logic [LANES*OPW-1:0]       in_all,
  input logic [LANES*DEPTH*OPW-1:0] stk_all,
  input logic [LANES*SELW-1:0]      sel_all
);
  localparam int LW = DEPTH * OPW;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R1
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> in_all[l*OPW +: OPW] == $past(din[l*OPW +: OPW]));
    // R2
    p_push_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !push_n[l] |=>
        (stk_all[l*LW +: OPW] == $past(in_all[l*OPW +: OPW])) &&
        (stk_all[l*LW + OPW +: LW - OPW] == $past(stk_all[l*LW +: LW - OPW])));
    // R3
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push_n[l] |=> $stable(stk_all[l*LW +: LW]));
    // R4
    p_tap_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sel_all[l*SELW +: SELW] == $past(tap_sel[l*SELW +: SELW]));
    // R5
    p_min_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_n[l] && tap_sel[l*SELW +: SELW] == '0) |=>
        dout[l*OPW +: OPW] == $past(in_all[l*OPW +: OPW]));
    // R8
    p_reset_tap_r8: assert property (@(posedge clk)
      !rst_n |-> sel_all[l*SELW +: SELW] == '0);
  end
endmodule

bind tapstack_quad tapstack_quad_chk #(
  .OPW(OPW), .DEPTH(DEPTH), .LANES(LANES), .SELW(SELW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .push_n(push_n), .tap_sel(tap_sel),
  .dout(dout), .in_all(in_all), .stk_all(stk_all), .sel_all(sel_all)
);

// File: tb/sim_tapstack_quad.sv
module sim_tapstack_quad;
  localparam int OPW = 12, DEPTH = 16, LANES = 4, SELW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES*OPW-1:0]  din = '0;
  logic [LANES-1:0]      push_n = '0;
  logic [LANES*SELW-1:0] tap_sel = '0;
  logic [LANES*OPW-1:0]  dout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [OPW-1:0]  m_in  [LANES];
  logic [OPW-1:0]  m_stk [LANES][DEPTH];
  logic [SELW-1:0] m_sel [LANES];

  always #5 clk = ~clk;

  tapstack_quad u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .push_n(push_n),
    .tap_sel(tap_sel), .dout(dout)
  );

  function automatic logic [OPW-1:0] lane_out(int l);
    return dout[l*OPW +: OPW];
  endfunction

  task automatic check(string req, logic [OPW-1:0] act, logic [OPW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock edge: update the reference state, then move to the falling edge.
  task automatic step();
    @(posedge clk);
    for (int l = 0; l < LANES; l++) begin
      if (!push_n[l]) begin
        for (int k = DEPTH - 1; k > 0; k--) m_stk[l][k] = m_stk[l][k-1];
        m_stk[l][0] = m_in[l];
      end
      m_in[l]  = din[l*OPW +: OPW];
      m_sel[l] = rst_n ? tap_sel[l*SELW +: SELW] : '0;
    end
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int l = 0; l < LANES; l++) check(req, lane_out(l), m_stk[l][m_sel[l]]);
  endtask

  task automatic set_word(int l, logic [OPW-1:0] v);
    din[l*OPW +: OPW] = v;
  endtask

  task automatic t_fill_and_reset();
    push_n = '0;
    for (int c = 0; c < DEPTH + 2; c++) begin
      for (int l = 0; l < LANES; l++) set_word(l, OPW'(12'h100 * (l + 1) + c));
      tap_sel = 16'hFFFF;
      step();
    end
    // R8: tap word is held at 0 during reset
    check_all("R8");
    for (int l = 0; l < LANES; l++) check("R8", lane_out(l), m_stk[l][0]);
    rst_n = 1'b1;
    step();
    check_all("R4");
  endtask

  task automatic t_min_delay();
    push_n = '0;
    tap_sel = '0;
    set_word(0, 12'hA5C);
    step();
    set_word(0, 12'h001);
    step();
    check("R5", lane_out(0), 12'hA5C);
  endtask

  task automatic t_max_delay();
    push_n = '0;
    tap_sel = 16'h000F;
    set_word(0, 12'h3C7);
    step();
    for (int c = 0; c < DEPTH; c++) begin
      set_word(0, OPW'(c));
      step();
    end
    check("R6", lane_out(0), 12'h3C7);
  endtask

  task automatic t_sweep();
    push_n = '1;
    for (int s = 0; s < DEPTH; s++) begin
      tap_sel = {SELW'(s), SELW'(DEPTH - 1 - s), SELW'(s), SELW'(DEPTH - 1 - s)};
      step();
      check_all("R4");
    end
  endtask

  task automatic t_hold();
    logic [OPW-1:0] snap [DEPTH];
    push_n = '0;
    tap_sel = '0;
    set_word(1, 12'h111);
    step();
    step();
    for (int k = 0; k < DEPTH; k++) snap[k] = m_stk[1][k];
    push_n = 4'b0010;
    set_word(1, 12'hBAD);
    step();
    set_word(1, 12'h222);
    step();
    // R3: stack of lane 1 unchanged, scanned through the tap word
    push_n = '1;
    for (int k = 0; k < DEPTH; k++) begin
      tap_sel[SELW +: SELW] = SELW'(k);
      step();
      check("R3", lane_out(1), snap[k]);
    end
    // R1: capture register kept loading during hold, so 12'h222 is pushed next
    push_n = 4'b1101;
    tap_sel[SELW +: SELW] = '0;
    step();
    check("R1", lane_out(1), 12'h222);
  endtask

  task automatic t_lanes();
    push_n = 4'b0101;
    tap_sel = {4'd3, 4'd7, 4'd0, 4'd12};
    for (int c = 0; c < 20; c++) begin
      for (int l = 0; l < LANES; l++) set_word(l, OPW'((c * 37 + l * 501) ^ 12'h5A5));
      push_n = push_n ^ ((c % 3 == 0) ? 4'b1010 : 4'b0001);
      step();
      check_all("R7");
    end
  endtask

  task automatic t_reset_keeps_stack();
    logic [OPW-1:0] snap [LANES][DEPTH];
    push_n = '1;
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < DEPTH; k++) snap[l][k] = m_stk[l][k];
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      tap_sel = {4{SELW'(k)}};
      step();
      for (int l = 0; l < LANES; l++) check("R8", lane_out(l), snap[l][k]);
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      m_in[l] = 'x;
      m_sel[l] = '0;
      for (int k = 0; k < DEPTH; k++) m_stk[l][k] = 'x;
    end
    @(negedge clk);
    t_fill_and_reset();
    t_min_delay();
    t_max_delay();
    t_sweep();
    t_hold();
    t_lanes();
    t_reset_keeps_stack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule